// File: doc/BRIEF.md
# Addressed DAC Register Bank

This block holds the digital state behind an eight-channel, 12-bit digital-to-analogue converter. It takes complete 16-bit command words, each presented for one clock with a write strobe. The top four bits of a word choose a target and the low twelve bits carry the value. The targets are:

- a channel input register, one per channel;
- a pair target, which writes one channel and puts the bitwise complement in its neighbour;
- one of two control registers;
- a preset register.

Each channel has an output latch that copies its input register while the load pin is held low. A separate active-low preset pin forces every channel output to the preset value, without waiting for a clock. Decoded fields from the control registers appear as outputs: the reference selection, the daisy-chain enable, and per-channel enable and speed flags.

The word framing comes from a serial link outside this block. The codes go on to the converters.

Top module: `dac_regbank`

## Requirements
- R1: A write with address 0 to 7 (word bits 15:12) stores data bits 11:0 in the input register of channel 0 to 7 respectively. No other channel changes.
- R2: A write with address 12, 13, 14 or 15 stores the data in channel 0, 2, 4 or 6. The same write stores the bitwise complement of that data in channel 1, 3, 5 or 7.
- R3: When control register 0 bit 0 is 1, channel data is stored with bit 11 inverted, which converts two's complement to offset binary. On a pair write, the partner channel receives the complement of the converted value.
- R4: On each clock edge where load_n is low, every output latch takes the value its input register held before that edge. While load_n is high, the latches hold their values.
- R5: While preset_n is low, every code output shows the preset register value, with no clock needed. Before the preset register is first written, that value is zero. When preset_n returns high, the outputs show the latched codes again.
- R6: A write to address 11 changes no register. A cycle with wr_en low changes no register.
- R7: Address 8 writes control register 0, which drives three outputs:
  - ref_sel = {bit 2, bit 1};
  - chain_en = bit 3;
  - bit 4 powers down every channel.
- R8: Address 9 writes control register 1. Bits 3:0 drive ch_fast for channel pairs (0,1), (2,3), (4,5), (6,7). Bits 7:4 power down the same pairs. A channel's ch_enable bit is 0 when its pair is powered down or when control register 0 bit 4 is set.
- R9: After reset, all registers and latches are zero. So the codes read 0, ch_enable is all ones, and ch_fast, ref_sel and chain_en are 0.
- R10: Address 10 writes the preset register. Control and preset data are stored unconverted, even while the format bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Command word strobe, one clock per word |
| wr_word | input | 16 | Command word: address in 15:12, data in 11:0 |
| load_n | input | 1 | Active-low latch load |
| preset_n | input | 1 | Active-low asynchronous preset of all outputs |
| code_out | output | 96 | Channel codes, channel i at bits 12*i+11 : 12*i |
| ch_enable | output | 8 | Per-channel amplifier enable |
| ch_fast | output | 8 | Per-channel fast settling select |
| ref_sel | output | 2 | Reference selection code |
| chain_en | output | 1 | Daisy-chain output enable |

## Verification
Direct writes use a different arithmetic pattern per channel. This separates a wrong address decode from a wrong data path. Pair writes use all-ones, all-zeros, sign-only and mixed values, so a missing complement or a complement on the wrong channel shows up. The same writes are repeated in two's-complement mode to show that the bit-11 inversion is applied before the complement.

Control register 1 is swept over all 256 values and control register 0 over all 32 values, to check every enable, speed and reference mapping. Load, preset and reserved-address cases are checked both before and after the latch update, which shows whether state moved when it should not.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL0     = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1     = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_PRESET    = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_PAIR_BASE = 4'd12;
  localparam int unsigned CTRL0_W = 5;
  localparam int unsigned C0_TWOS  = 0;
  localparam int unsigned C0_REF_LO = 1;
  localparam int unsigned C0_REF_HI = 2;
  localparam int unsigned C0_CHAIN = 3;
  localparam int unsigned C0_PD_ALL = 4;
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 8
) (
  input  logic                     wr_en,
  input  logic [ADDR_W+CODE_W-1:0] word,
  input  logic                     twos_mode,
  output logic [NUM_CH-1:0]        ch_we,
  output logic [CODE_W-1:0]        ch_data [NUM_CH],
  output logic                     ctrl0_we,
  output logic                     ctrl1_we,
  output logic                     preset_we,
  output logic [CODE_W-1:0]        raw_data
);
  localparam int PAIRS = NUM_CH / 2;
  localparam logic [CODE_W-1:0] SIGN_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] conv;

  assign addr     = word[ADDR_W+CODE_W-1:CODE_W];
  assign raw_data = word[CODE_W-1:0];
  assign conv     = twos_mode ? (raw_data ^ SIGN_MASK) : raw_data;

  assign ctrl0_we  = wr_en && (addr == ADDR_CTRL0);
  assign ctrl1_we  = wr_en && (addr == ADDR_CTRL1);
  assign preset_we = wr_en && (addr == ADDR_PRESET);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ch_data[i] = conv;
      ch_we[i]   = wr_en && (addr == ADDR_W'(i));
    end
    for (int p = 0; p < PAIRS; p++) begin
      if (wr_en && (addr == ADDR_PAIR_BASE + ADDR_W'(p))) begin
        ch_we[2*p]     = 1'b1;
        ch_we[2*p+1]   = 1'b1;
        ch_data[2*p+1] = ~conv;
      end
    end
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] din,
  input  logic              load_n,
  input  logic              preset_n,
  input  logic [CODE_W-1:0] preset_val,
  output logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] in_q, in_d;
  logic [CODE_W-1:0] out_q, out_d;

  always_comb begin
    in_d  = we ? din : in_q;
    out_d = load_n ? out_q : in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign in_code = in_q;
  assign code    = preset_n ? out_q : preset_val;

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(out_q));
  p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (out_q == $past(in_q)));
  p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(in_q));
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dacbank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W+CODE_W-1:0]   wr_word,
  input  logic                       load_n,
  input  logic                       preset_n,
  output logic [NUM_CH*CODE_W-1:0]   code_out,
  output logic [NUM_CH-1:0]          ch_enable,
  output logic [NUM_CH-1:0]          ch_fast,
  output logic [1:0]                 ref_sel,
  output logic                       chain_en
);
  localparam int PAIRS   = NUM_CH / 2;
  localparam int CTRL1_W = 2 * PAIRS;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_CH-1:0] ch_we;
  logic [CODE_W-1:0] ch_data [NUM_CH];
  logic              ctrl0_we, ctrl1_we, preset_we;
  logic [CODE_W-1:0] raw_data;

  logic [CTRL0_W-1:0] ctrl0_q, ctrl0_d;
  logic [CTRL1_W-1:0] ctrl1_q, ctrl1_d;
  logic [CODE_W-1:0]  preset_q, preset_d;
  logic [NUM_CH*CODE_W-1:0] in_flat;

  dacbank_decode #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_decode (
    .wr_en     (wr_en),
    .word      (wr_word),
    .twos_mode (ctrl0_q[C0_TWOS]),
    .ch_we     (ch_we),
    .ch_data   (ch_data),
    .ctrl0_we  (ctrl0_we),
    .ctrl1_we  (ctrl1_we),
    .preset_we (preset_we),
    .raw_data  (raw_data)
  );

  always_comb begin
    ctrl0_d  = ctrl0_we  ? raw_data[CTRL0_W-1:0] : ctrl0_q;
    ctrl1_d  = ctrl1_we  ? raw_data[CTRL1_W-1:0] : ctrl1_q;
    preset_d = preset_we ? raw_data              : preset_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl0_q  <= '0;
      ctrl1_q  <= '0;
      preset_q <= '0;
    end else begin
      ctrl0_q  <= ctrl0_d;
      ctrl1_q  <= ctrl1_d;
      preset_q <= preset_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dacbank_chan #(.CODE_W(CODE_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .we         (ch_we[i]),
      .din        (ch_data[i]),
      .load_n     (load_n),
      .preset_n   (preset_n),
      .preset_val (preset_q),
      .in_code    (in_flat[i*CODE_W +: CODE_W]),
      .code       (code_out[i*CODE_W +: CODE_W])
    );
    assign ch_enable[i] = ~(ctrl0_q[C0_PD_ALL] | ctrl1_q[PAIRS + i/2]);
    assign ch_fast[i]   = ctrl1_q[i/2];
  end

  assign ref_sel  = {ctrl0_q[C0_REF_HI], ctrl0_q[C0_REF_LO]};
  assign chain_en = ctrl0_q[C0_CHAIN];

  p_reserved_ignored_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_word[ADDR_W+CODE_W-1:CODE_W] == 4'd11)
      |=> ($stable(ctrl0_q) && $stable(ctrl1_q) && $stable(preset_q) && $stable(in_flat)));

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair_chk
    p_pair_complement_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && wr_word[ADDR_W+CODE_W-1:CODE_W] == ADDR_PAIR_BASE + ADDR_W'(p))
        |=> (in_flat[(2*p)*CODE_W +: CODE_W] == ~in_flat[(2*p+1)*CODE_W +: CODE_W]));
  end
endmodule

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;
  localparam int CW = 12;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n, wr_en, load_n, preset_n;
  logic [15:0] wr_word;
  logic [NC*CW-1:0] code_out;
  logic [NC-1:0] ch_enable, ch_fast;
  logic [1:0] ref_sel;
  logic chain_en;

  always #5 clk = ~clk;

  dac_regbank u_dac_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .load_n(load_n), .preset_n(preset_n), .code_out(code_out),
    .ch_enable(ch_enable), .ch_fast(ch_fast), .ref_sel(ref_sel), .chain_en(chain_en)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [CW-1:0] m_in  [NC];
  logic [CW-1:0] m_out [NC];
  logic [4:0]    m_c0;
  logic [7:0]    m_c1;
  logic [CW-1:0] m_pre;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NC; i++) begin
      logic [CW-1:0] e;
      e = preset_n ? m_out[i] : m_pre;
      check_eq(tag, 32'(code_out[i*CW +: CW]), 32'(e));
    end
    for (int i = 0; i < NC; i++) begin
      check_eq({tag, " enable R8"}, 32'(ch_enable[i]), 32'(!(m_c0[4] | m_c1[4 + i/2])));
      check_eq({tag, " fast R8"}, 32'(ch_fast[i]), 32'(m_c1[i/2]));
    end
    check_eq({tag, " ref R7"}, 32'(ref_sel), 32'(m_c0[2:1]));
    check_eq({tag, " chain R7"}, 32'(chain_en), 32'(m_c0[3]));
  endtask

  task automatic cycle(input bit w, input logic [15:0] word);
    logic [3:0] a;
    logic [CW-1:0] d, cv;
    wr_en = w;
    wr_word = word;
    @(posedge clk);
    if (!load_n) for (int i = 0; i < NC; i++) m_out[i] = m_in[i];
    if (w) begin
      a = word[15:12];
      d = word[11:0];
      cv = m_c0[0] ? (d ^ 12'h800) : d;
      if (a < 8) m_in[a] = cv;
      else if (a == 8) m_c0 = d[4:0];
      else if (a == 9) m_c1 = d[7:0];
      else if (a == 10) m_pre = d;
      else if (a >= 12) begin
        m_in[2*(a-12)] = cv;
        m_in[2*(a-12)+1] = ~cv;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_load();
    load_n = 1'b0;
    cycle(0, 16'h0);
    load_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_word = '0; load_n = 1'b1; preset_n = 1'b1;
    for (int i = 0; i < NC; i++) begin m_in[i] = '0; m_out[i] = '0; end
    m_c0 = '0; m_c1 = '0; m_pre = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9 reset");

    // R1 direct channel writes with per-channel patterns
    for (int k = 0; k < 4; k++) begin
      for (int ch = 0; ch < NC; ch++) begin
        logic [CW-1:0] v;
        v = CW'(ch * 12'h123 + k * 12'h5A5 + 1);
        cycle(1, {4'(ch), v});
      end
      check_all("R4 hold before load");
      do_load();
      check_all("R1 direct write");
    end

    // R5 preset never written reads as zero
    preset_n = 1'b0; #1;
    check_all("R5 preset default zero");
    preset_n = 1'b1; #1;
    check_all("R5 preset release");

    // R4 load held low: output lags input register by one edge
    load_n = 1'b0;
    cycle(0, 16'h0);
    cycle(1, {4'd3, 12'hABC});
    check_all("R4 old value at write edge");
    cycle(0, 16'h0);
    check_all("R4 transparent update");
    load_n = 1'b1;

    // R2 pair writes
    for (int p = 0; p < 4; p++) begin
      logic [CW-1:0] vals [4];
      vals[0] = 12'hFFF; vals[1] = 12'h000; vals[2] = 12'h5A3; vals[3] = 12'h800;
      for (int j = 0; j < 4; j++) begin
        cycle(1, {4'(12 + p), vals[j]});
        do_load();
        check_all("R2 pair complement");
      end
    end

    // R6 reserved address and idle cycles
    cycle(1, {4'd11, 12'hFFF});
    cycle(0, {4'd0, 12'h777});
    do_load();
    check_all("R6 reserved ignored");

    // R3 two's complement mode
    cycle(1, {4'd8, 12'h001});
    for (int ch = 0; ch < NC; ch++) cycle(1, {4'(ch), CW'(12'h7F0 + ch * 12'h101)});
    do_load();
    check_all("R3 twos direct");
    cycle(1, {4'd12, 12'h000});
    cycle(1, {4'd15, 12'hFFF});
    cycle(1, {4'd13, 12'h123});
    do_load();
    check_all("R3 twos pair");

    // R10 preset and control stored unconverted in twos mode
    cycle(1, {4'd10, 12'hC35});
    preset_n = 1'b0; #1;
    check_all("R10 R5 preset forced");
    preset_n = 1'b1; #1;
    check_all("R5 preset released");
    cycle(1, {4'd8, 12'h000});

    // R8 control register 1 sweep
    for (int v = 0; v < 256; v++) begin
      cycle(1, {4'd9, 4'h0, 8'(v)});
      check_all("R8 ctrl1 sweep");
    end
    // R7 control register 0 sweep
    for (int v = 0; v < 32; v++) begin
      cycle(1, {4'd8, 7'h0, 5'(v)});
      check_all("R7 ctrl0 sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule